// File: doc/BRIEF.md
# Binary 7x7 Sliding Window Generator

This block takes a raster-ordered stream of one-bit pixels and shows, on every clock, the full 7x7 neighbourhood that ends at the most recently accepted pixel. A spatial operator placed after it, such as an erosion-style vote, can then read all 49 bits at once. Six row delays are chained one after another. Each row delay is a one-bit synchronous FIFO with a registered read port, followed by a seven-stage register tap chain, so each row delay adds up to one full row of 640 pixels.

A row FIFO starts to give back data once its own fill count reaches a threshold. That threshold is set two entries below the FIFO's share of the row, so that the registered read data and the first tap stage make up the difference. From that point on, the next FIFO down the chain is written on every accepted pixel. Pixels move forward only on cycles where the valid input is high. A frame-start pulse clears every FIFO, every count and every register, so that rows which lie above the top of the image read as zero.

Top module: `bwin_window_gen`

## Requirements
- R1: After reset, and in the cycle after a frame-start pulse, all 49 window bits are 0. A pixel presented in the same cycle as frame start is discarded.
- R2: On each cycle with pix_valid high and frame_start low, window bit 0 (row 0, column 0) holds that cycle's pix_in from the next cycle on.
- R3: On each accepted pixel, window bit r*7+c for c from 1 to 6 takes the previous value of bit r*7+c-1 in the same row r.
- R4: On a cycle with pix_valid low, all 49 window bits keep their values, whatever pix_in is.
- R5: Once n pixels have been accepted since frame start, window bit r*7+c holds the pixel with index n-1-640*r-c. Row r therefore lies exactly r rows of 640 pixels above row 0.
- R6: A window position whose pixel index from R5 is negative reads 0.
- R7: Each row FIFO starts releasing on the accepted pixel after the one at which its fill count was 631. It never holds more than 632 entries, and it keeps releasing until the next frame start. The first pixel of the frame reaches window bit 7 when pixel 640 is accepted.
- R8: The alignment of R5 holds when idle cycles are placed anywhere in the stream.
- R9: A frame-start pulse in the middle of a frame drops everything stored before it. No data from the old frame appears in any window bit afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Synchronous clear of all storage; the pixel in this cycle is dropped |
| pix_valid | input | 1 | High when pix_in carries a pixel to accept |
| pix_in | input | 1 | Binary pixel, raster order |
| win_o | output | 49 | Window bit r*7+c; row 0 is the newest row and column 0 the newest pixel |

## Verification
Every accepted pixel appears at window bit 0, and moves one column along a row, exactly one clock edge after it is presented. A pixel stored in a row FIFO reaches the first column of the next row exactly 640 accepted pixels later, so that delay is counted in pixels and not in cycles. The bench drives each input one nanosecond after a rising edge and samples the window one nanosecond after the next rising edge. At that point it compares all 49 bits with a model that indexes its own record of accepted pixels, so idle cycles do not shift any expected value. The first row handoff is also checked on its own, in the exact pixel where the R7 threshold sends it.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
    // Default geometry of the window generator
    localparam int unsigned ROW_LEN_DEF = 640;
    localparam int unsigned WIN_DEF     = 7;
    localparam int unsigned DEPTH_DEF   = 1024;
    // Cycles of latency between a FIFO pop and the first tap of the next row
    localparam int unsigned HANDOFF_LAT = 2;
endpackage

// File: rtl/bwin_row_fifo.sv
module bwin_row_fifo
    import bwin_pkg::*;
#(
    parameter int unsigned DEPTH  = DEPTH_DEF,
    parameter int unsigned THRESH = ROW_LEN_DEF - WIN_DEF - HANDOFF_LAT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     step_i,
    input  logic                     wr_en_i,
    input  logic                     wr_bit_i,
    output logic                     rd_act_o,
    output logic                     rd_bit_o,
    output logic [$clog2(DEPTH)-1:0] fill_o
);
    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW-1:0] fill;
        logic          act;
        logic          rdat;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     mem [DEPTH];
    logic     do_wr, do_rd;

    always_comb begin
        do_wr = step_i & wr_en_i & ~clr_i;
        do_rd = step_i & st_q.act & ~clr_i;
        st_d  = st_q;
        if (clr_i) begin
            st_d = '0;
        end else begin
            if (do_wr) begin
                st_d.wptr = st_q.wptr + AW'(1);
            end
            if (do_rd) begin
                st_d.rptr = st_q.rptr + AW'(1);
                st_d.rdat = mem[st_q.rptr];
            end
            st_d.fill = st_q.fill + AW'(do_wr) - AW'(do_rd);
            // Sticky release once the count hits the lowered threshold
            if (step_i && (st_q.fill == AW'(THRESH))) begin
                st_d.act = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Storage array, no reset so it maps onto block memory
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[st_q.wptr] <= wr_bit_i;
        end
    end

    assign rd_act_o = st_q.act;
    assign rd_bit_o = st_q.rdat;
    assign fill_o   = st_q.fill;
endmodule

// File: rtl/bwin_tap_row.sv
module bwin_tap_row
    import bwin_pkg::*;
#(
    parameter int unsigned WIN = WIN_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_i,
    input  logic           step_i,
    input  logic           in_bit_i,
    output logic [WIN-1:0] taps_o
);
    logic [WIN-1:0] taps_d, taps_q;

    always_comb begin
        taps_d = taps_q;
        if (clr_i) begin
            taps_d = '0;
        end else if (step_i) begin
            taps_d = {taps_q[WIN-2:0], in_bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q <= '0;
        end else begin
            taps_q <= taps_d;
        end
    end

    assign taps_o = taps_q;
endmodule

// File: rtl/bwin_window_gen.sv
module bwin_window_gen
    import bwin_pkg::*;
#(
    parameter int unsigned ROW_LEN = ROW_LEN_DEF,
    parameter int unsigned WIN     = WIN_DEF,
    parameter int unsigned DEPTH   = DEPTH_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               pix_valid,
    input  logic               pix_in,
    output logic [WIN*WIN-1:0] win_o
);
    localparam int unsigned NBUF   = WIN - 1;
    localparam int unsigned THRESH = ROW_LEN - WIN - HANDOFF_LAT;
    localparam int unsigned AW     = $clog2(DEPTH);

    logic               step;
    logic [NBUF-1:0]    rd_act;
    logic [NBUF-1:0]    rd_bit;
    logic [NBUF*AW-1:0] fill_flat;

    assign step = pix_valid & ~frame_start;

    for (genvar r = 0; r < WIN; r++) begin : g_row
        logic in_bit;
        if (r == 0) begin : g_head
            assign in_bit = pix_in;
        end else begin : g_link
            assign in_bit = rd_bit[r-1];
        end
        bwin_tap_row #(.WIN(WIN)) u_taps (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (frame_start),
            .step_i   (step),
            .in_bit_i (in_bit),
            .taps_o   (win_o[r*WIN +: WIN])
        );
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic wr_en;
        if (b == 0) begin : g_first
            assign wr_en = 1'b1;
        end else begin : g_chain
            assign wr_en = rd_act[b-1];
        end
        bwin_row_fifo #(.DEPTH(DEPTH), .THRESH(THRESH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (frame_start),
            .step_i   (step),
            .wr_en_i  (wr_en),
            .wr_bit_i (win_o[b*WIN + WIN - 1]),
            .rd_act_o (rd_act[b]),
            .rd_bit_o (rd_bit[b]),
            .fill_o   (fill_flat[b*AW +: AW])
        );
    end
endmodule

// File: rtl/bwin_win_chk.sv
module bwin_win_chk #(
    parameter int unsigned WIN    = 7,
    parameter int unsigned NBUF   = 6,
    parameter int unsigned AW     = 10,
    parameter int unsigned THRESH = 631
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               pix_valid,
    input logic               pix_in,
    input logic [WIN*WIN-1:0] win_o,
    input logic [NBUF-1:0]    rd_act,
    input logic [NBUF-1:0]    rd_bit,
    input logic [NBUF*AW-1:0] fill_flat
);
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (win_o == '0));

    a_r2_newest: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !frame_start) |=> (win_o[0] == $past(pix_in)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid && !frame_start) |=> $stable(win_o));

    for (genvar r = 0; r < WIN; r++) begin : g_rowchk
        a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && !frame_start)
            |=> (win_o[r*WIN+1 +: WIN-1] == $past(win_o[r*WIN +: WIN-1])));
    end

    for (genvar b = 0; b < NBUF; b++) begin : g_bufchk
        a_r5_link: assert property (@(posedge clk) disable iff (!rst_n)
            (pix_valid && !frame_start) |=> (win_o[(b+1)*WIN] == $past(rd_bit[b])));

        a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
            fill_flat[b*AW +: AW] <= AW'(THRESH + 1));

        a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_act[b]) |-> ($past(fill_flat[b*AW +: AW]) == AW'(THRESH)));

        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_act[b] && !frame_start) |=> rd_act[b]);

        a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
            frame_start |=> (!rd_act[b] && (fill_flat[b*AW +: AW] == '0)));
    end
endmodule

bind bwin_window_gen bwin_win_chk #(
    .WIN    (WIN),
    .NBUF   (NBUF),
    .AW     (AW),
    .THRESH (THRESH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .pix_in      (pix_in),
    .win_o       (win_o),
    .rd_act      (rd_act),
    .rd_bit      (rd_bit),
    .fill_flat   (fill_flat)
);

// File: tb/bwin_window_gen_tb.sv
module bwin_window_gen_tb;
    localparam int ROW = 640;
    localparam int W   = 7;
    localparam int MAXP = 8192;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_start = 1'b0;
    logic         pix_valid = 1'b0;
    logic         pix_in = 1'b0;
    logic [W*W-1:0] win_o;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  pm [MAXP];
    int  nacc = 0;

    always #2 clk = ~clk;

    bwin_window_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pix_valid   (pix_valid),
        .pix_in      (pix_in),
        .win_o       (win_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (pixels=%0d)", tag, act, exp, nacc);
        end
    endtask

    function automatic bit exp_bit(input int r, input int c);
        int idx;
        idx = nacc - 1 - r*ROW - c;
        return (idx >= 0) ? pm[idx] : 1'b0;
    endfunction

    function automatic bit pattern(input int mode, input int idx);
        int unsigned h;
        case (mode)
            0: return 1'(((idx % ROW) + (idx / ROW)) & 1);
            1: begin
                h = 32'(idx) * 32'h9E3779B1;
                return h[13] ^ h[21];
            end
            default: return (idx == 645) || (idx == 1290);
        endcase
    endfunction

    // One clock: inputs already driven, wait the edge, sample 1 ns later
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_window(input string early_tag, input string late_tag);
        logic [W-1:0]     e0;
        logic [W*W-1:0]   er;
        string            rt;
        e0 = '0;
        er = '0;
        for (int c = 0; c < W; c++) e0[c] = exp_bit(0, c);
        for (int r = 1; r < W; r++)
            for (int c = 0; c < W; c++) er[r*W+c] = exp_bit(r, c);
        // R2: newest bit; R3: row 0 shift
        check("R2", 64'(win_o[0]), 64'(e0[0]));
        check("R3", 64'(win_o[W-1:1]), 64'(e0[W-1:1]));
        // R5/R6/R8/R9: upper rows against pixel record
        rt = (nacc <= (W-1)*ROW + W) ? early_tag : late_tag;
        check(rt, 64'(win_o[W*W-1:W]), 64'(er[W*W-1:W]));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1", 64'(win_o), 64'(0));
    endtask

    task automatic t_run(input int mode, input bit stalls, input int npix,
                         input string early_tag, input string late_tag);
        logic [W*W-1:0] held;
        // frame start with a valid pixel that must be dropped (R1)
        frame_start = 1'b1;
        pix_valid = 1'b1;
        pix_in = 1'b1;
        tick();
        frame_start = 1'b0;
        pix_valid = 1'b0;
        nacc = 0;
        check("R1", 64'(win_o), 64'(0));
        for (int p = 0; p < npix; p++) begin
            pm[p] = pattern(mode, p);
            pix_valid = 1'b1;
            pix_in = pm[p];
            tick();
            nacc = p + 1;
            pix_valid = 1'b0;
            check_window(early_tag, late_tag);
            if (nacc == ROW + 1) begin
                // R7: first handoff lands in row 1 exactly now
                check("R7", 64'(win_o[W]), 64'(pm[0]));
            end
            if (stalls && (p % 97 == 13)) begin
                held = win_o;
                for (int k = 0; k < 3; k++) begin
                    pix_in = ~pix_in;
                    tick();
                end
                check("R4", 64'(win_o), 64'(held));
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_run(0, 1'b0, 4600, "R6", "R5");
        t_run(1, 1'b1, 4600, "R6", "R8");
        t_run(1, 1'b0, 2000, "R6", "R5");
        t_run(2, 1'b0, 4600, "R9", "R5");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule